// File: doc/BRIEF.md
# Region Address Translator

This block translates a virtual address into a physical address using a fixed table of eight equal regions. The table is indexed directly by the top three address bits, so each region covers 512 MiB. Every region entry holds a physical region base and a 4-bit attribute. The attribute decodes into read, write and execute permissions. Lookups are combinational: the physical address, the region span, the permission bits and any denial cause appear in the same cycle as the address and the access type.

Entries are rewritten through a synchronous write port that takes an index, a base and an attribute. The physical address is the stored base region number placed above the untouched in-region offset. Two instances are normally placed in a system. The data-side variant checks loads against read permission, stores against write permission and fetches against execute permission. The instruction-side variant checks every access against execute permission.

Top module: `rxl_region_xlate`

## Requirements
- R1: After reset, region i maps to physical region i (so the physical address equals the virtual address) and every region has attribute 2, which grants read, write and execute.
- R2: The physical address equals the stored base region number of region va[31:29], placed in bits 31:29, with va[28:0] passed through unchanged.
- R3: The span output always reads 0x2000_0000 (512 MiB).
- R4: Read and write permission are both granted exactly when the attribute is below 6 and not 3, or when it is 14.
- R5: Execute permission is granted exactly when the attribute is 1, 2, 3, 4 or 5.
- R6: In the data-side variant (SIDE_DATA=1), access type 1 (store) is checked against write, type 2 (fetch) against execute, and types 0 and 3 against read. A denial raises deny with cause 2 for a store, 3 for a fetch and 1 for a load. Without a denial, deny is 0 and cause is 0.
- R7: In the instruction-side variant (SIDE_DATA=0), every access type is checked against execute permission. A denial gives deny=1 with cause 3; otherwise deny=0 and cause=0.
- R8: A write with wr_en high at a rising clock edge replaces the base and attribute of entry wr_idx. The new values are visible to lookups from the next cycle, and the other seven entries are unchanged.
- R9: Bits 28:0 of wr_base are discarded; only bits 31:29 are stored.
- R10: With wr_en low, the values on wr_idx, wr_base and wr_attr change no entry.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset, loads the identity map |
| wr_en | input | 1 | Entry write strobe |
| wr_idx | input | 3 | Entry to be written |
| wr_base | input | 32 | New physical base (upper 3 bits kept) |
| wr_attr | input | 4 | New attribute |
| va | input | 32 | Virtual address to translate |
| acc_type | input | 2 | 0 load, 1 store, 2 fetch, 3 treated as load |
| pa | output | 32 | Physical address |
| span | output | 32 | Region size in bytes |
| perm_r | output | 1 | Region grants read |
| perm_w | output | 1 | Region grants write |
| perm_x | output | 1 | Region grants execute |
| deny | output | 1 | Access refused |
| cause | output | 2 | 0 none, 1 load refused, 2 store refused, 3 fetch refused |

## Verification
Because the lookup is combinational, a corrupted entry shows at the ports as soon as any address falls in that region. A wrong base makes pa bits 31:29 differ from the bench model. A wrong attribute changes the permission bits and, depending on the access type, deny and cause. A write that lands on the wrong entry, or that takes effect with the strobe low, appears one cycle after the edge. The bench catches it there because it probes all eight regions after every write.

// File: rtl/rxl_pkg.sv
package rxl_pkg;

   typedef enum logic [1:0] {
      ACC_LOAD  = 2'd0,
      ACC_STORE = 2'd1,
      ACC_FETCH = 2'd2,
      ACC_RSVD  = 2'd3
   } acc_kind_e;

   typedef enum logic [1:0] {
      CZ_NONE  = 2'd0,
      CZ_LOAD  = 2'd1,
      CZ_STORE = 2'd2,
      CZ_FETCH = 2'd3
   } deny_cause_e;

   typedef struct packed {
      logic r;
      logic w;
      logic x;
   } perm_t;

endpackage

// File: rtl/rxl_table.sv
module rxl_table #(
   parameter int IDX_W    = 3,
   parameter int ATTR_W   = 4,
   parameter int RST_ATTR = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [IDX_W-1:0]  wr_idx,
   input  logic [IDX_W-1:0]  wr_reg,
   input  logic [ATTR_W-1:0] wr_attr,
   input  logic [IDX_W-1:0]  rd_idx,
   output logic [IDX_W-1:0]  rd_reg,
   output logic [ATTR_W-1:0] rd_attr
);
   localparam int NREG = 1 << IDX_W;

   logic [IDX_W-1:0]  reg_arr  [NREG];
   logic [ATTR_W-1:0] attr_arr [NREG];

   for (genvar i = 0; i < NREG; i++) begin : g_ent
      localparam logic [IDX_W-1:0]  RST_REG = IDX_W'(i);
      localparam logic [ATTR_W-1:0] RST_A   = ATTR_W'(RST_ATTR);
      logic [IDX_W-1:0]  reg_q;
      logic [ATTR_W-1:0] attr_q;
      logic              hit;

      assign hit = wr_en && (wr_idx == RST_REG);

      always_ff @(posedge clk) begin
         if (!rst_n) begin
            reg_q  <= RST_REG;
            attr_q <= RST_A;
         end else if (hit) begin
            reg_q  <= wr_reg;
            attr_q <= wr_attr;
         end
      end

      assign reg_arr[i]  = reg_q;
      assign attr_arr[i] = attr_q;
   end

   assign rd_reg  = reg_arr[rd_idx];
   assign rd_attr = attr_arr[rd_idx];
endmodule

// File: rtl/rxl_perm_decode.sv
module rxl_perm_decode #(
   parameter int ATTR_W = 4
) (
   input  logic [ATTR_W-1:0] attr,
   output rxl_pkg::perm_t    perm
);
   localparam logic [ATTR_W-1:0] A_NORW = ATTR_W'(3);
   localparam logic [ATTR_W-1:0] A_RWLIM = ATTR_W'(6);
   localparam logic [ATTR_W-1:0] A_BYP = ATTR_W'(14);
   localparam logic [ATTR_W-1:0] A_XLO = ATTR_W'(1);
   localparam logic [ATTR_W-1:0] A_XHI = ATTR_W'(5);

   logic rw_ok;
   logic x_ok;

   always_comb begin
      rw_ok = ((attr < A_RWLIM) && (attr != A_NORW)) || (attr == A_BYP);
      x_ok  = (attr >= A_XLO) && (attr <= A_XHI);
      perm  = '{r: rw_ok, w: rw_ok, x: x_ok};
   end
endmodule

// File: rtl/rxl_access_check.sv
module rxl_access_check #(
   parameter bit SIDE_DATA = 1'b1
) (
   input  logic [1:0]     acc_type,
   input  rxl_pkg::perm_t perm,
   output logic           deny,
   output logic [1:0]     cause
);
   import rxl_pkg::*;

   deny_cause_e cz;

   if (SIDE_DATA) begin : g_data
      always_comb begin
         unique case (acc_kind_e'(acc_type))
            ACC_STORE: cz = perm.w ? CZ_NONE : CZ_STORE;
            ACC_FETCH: cz = perm.x ? CZ_NONE : CZ_FETCH;
            default:   cz = perm.r ? CZ_NONE : CZ_LOAD;
         endcase
      end
   end else begin : g_insn
      logic unused_type;
      logic unused_rw;
      assign unused_type = ^acc_type;
      assign unused_rw   = perm.r ^ perm.w;
      always_comb cz = perm.x ? CZ_NONE : CZ_FETCH;
   end

   assign cause = cz;
   assign deny  = (cz != CZ_NONE);
endmodule

// File: rtl/rxl_region_xlate.sv
module rxl_region_xlate #(
   parameter int ADDR_W    = 32,
   parameter int IDX_W     = 3,
   parameter int ATTR_W    = 4,
   parameter int RST_ATTR  = 2,
   parameter bit SIDE_DATA = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [IDX_W-1:0]  wr_idx,
   input  logic [ADDR_W-1:0] wr_base,
   input  logic [ATTR_W-1:0] wr_attr,
   input  logic [ADDR_W-1:0] va,
   input  logic [1:0]        acc_type,
   output logic [ADDR_W-1:0] pa,
   output logic [ADDR_W-1:0] span,
   output logic              perm_r,
   output logic              perm_w,
   output logic              perm_x,
   output logic              deny,
   output logic [1:0]        cause
);
   import rxl_pkg::*;

   localparam int OFF_W = ADDR_W - IDX_W;
   localparam logic [ADDR_W-1:0] SPAN_C = {{(ADDR_W-1){1'b0}}, 1'b1} << OFF_W;

   if (IDX_W < 1 || IDX_W > 8) begin : g_bad_idx
      $error("rxl_region_xlate: IDX_W must lie in 1..8");
   end
   if (ADDR_W <= IDX_W) begin : g_bad_addr
      $error("rxl_region_xlate: ADDR_W must exceed IDX_W");
   end
   if (ATTR_W != 4) begin : g_bad_attr
      $error("rxl_region_xlate: attribute decode needs ATTR_W of 4");
   end
   if (RST_ATTR < 0 || RST_ATTR >= (1 << ATTR_W)) begin : g_bad_rst
      $error("rxl_region_xlate: RST_ATTR out of range");
   end

   logic [IDX_W-1:0]  rd_idx;
   logic [IDX_W-1:0]  rd_reg;
   logic [ATTR_W-1:0] rd_attr;
   logic [OFF_W-1:0]  va_off;
   logic              unused_wlo;
   perm_t             perm;

   assign rd_idx     = va[ADDR_W-1:OFF_W];
   assign va_off     = va[OFF_W-1:0];
   assign unused_wlo = ^wr_base[OFF_W-1:0];

   rxl_table #(
      .IDX_W   (IDX_W),
      .ATTR_W  (ATTR_W),
      .RST_ATTR(RST_ATTR)
   ) u_table (
      .clk    (clk),
      .rst_n  (rst_n),
      .wr_en  (wr_en),
      .wr_idx (wr_idx),
      .wr_reg (wr_base[ADDR_W-1:OFF_W]),
      .wr_attr(wr_attr),
      .rd_idx (rd_idx),
      .rd_reg (rd_reg),
      .rd_attr(rd_attr)
   );

   rxl_perm_decode #(
      .ATTR_W(ATTR_W)
   ) u_perm (
      .attr(rd_attr),
      .perm(perm)
   );

   rxl_access_check #(
      .SIDE_DATA(SIDE_DATA)
   ) u_chk_acc (
      .acc_type(acc_type),
      .perm    (perm),
      .deny    (deny),
      .cause   (cause)
   );

   assign pa     = {rd_reg, va_off};
   assign span   = SPAN_C;
   assign perm_r = perm.r;
   assign perm_w = perm.w;
   assign perm_x = perm.x;
endmodule

// File: rtl/rxl_region_xlate_chk.sv
module rxl_region_xlate_chk #(
   parameter int ADDR_W    = 32,
   parameter int IDX_W     = 3,
   parameter int ATTR_W    = 4,
   parameter bit SIDE_DATA = 1'b1
) (
   input logic              clk,
   input logic              rst_n,
   input logic              wr_en,
   input logic [IDX_W-1:0]  wr_idx,
   input logic [ADDR_W-1:0] wr_base,
   input logic [ATTR_W-1:0] wr_attr,
   input logic [ADDR_W-1:0] va,
   input logic [1:0]        acc_type,
   input logic [ADDR_W-1:0] pa,
   input logic              perm_r,
   input logic              perm_w,
   input logic              perm_x,
   input logic              deny,
   input logic [1:0]        cause
);
   localparam int OFF_W = ADDR_W - IDX_W;

   logic seen_q;
   always_ff @(posedge clk) begin
      if (!rst_n) seen_q <= 1'b0;
      else        seen_q <= 1'b1;
   end

   p_offset_pass_r2: assert property (@(posedge clk) disable iff (!rst_n)
      pa[OFF_W-1:0] == va[OFF_W-1:0]);

   p_rw_pair_r4: assert property (@(posedge clk) disable iff (!rst_n)
      perm_r == perm_w);

   p_deny_cause_r6: assert property (@(posedge clk) disable iff (!rst_n)
      deny == (cause != 2'd0));

   p_write_lands_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (seen_q && $past(wr_en) && ($past(wr_idx) == va[ADDR_W-1:OFF_W]))
      |-> (pa[ADDR_W-1:OFF_W] == $past(wr_base[ADDR_W-1:OFF_W])));

   p_write_attr_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (seen_q && $past(wr_en) && ($past(wr_idx) == va[ADDR_W-1:OFF_W])
       && ($past(wr_attr) == 4'd14)) |-> (perm_r && !perm_x));

   p_idle_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (seen_q && !$past(wr_en) && $stable(va) && $stable(acc_type))
      |-> ($stable(pa) && $stable(perm_r) && $stable(perm_x) && $stable(cause)));

   if (SIDE_DATA) begin : g_data
      p_store_cause_r6: assert property (@(posedge clk) disable iff (!rst_n)
         (acc_type == 2'd1) |-> (deny == !perm_w) && (!deny || cause == 2'd2));
   end else begin : g_insn
      p_fetch_only_r7: assert property (@(posedge clk) disable iff (!rst_n)
         (deny == !perm_x) && (!deny || cause == 2'd3));
   end
endmodule

bind rxl_region_xlate rxl_region_xlate_chk #(
   .ADDR_W   (ADDR_W),
   .IDX_W    (IDX_W),
   .ATTR_W   (ATTR_W),
   .SIDE_DATA(SIDE_DATA)
) u_rxl_chk (
   .clk     (clk),
   .rst_n   (rst_n),
   .wr_en   (wr_en),
   .wr_idx  (wr_idx),
   .wr_base (wr_base),
   .wr_attr (wr_attr),
   .va      (va),
   .acc_type(acc_type),
   .pa      (pa),
   .perm_r  (perm_r),
   .perm_w  (perm_w),
   .perm_x  (perm_x),
   .deny    (deny),
   .cause   (cause)
);

// File: tb/rxl_region_xlate_tb_top.sv
module rxl_region_xlate_tb_top;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        wr_en = 1'b0;
   logic [2:0]  wr_idx = '0;
   logic [31:0] wr_base = '0;
   logic [3:0]  wr_attr = '0;
   logic [31:0] va = '0;
   logic [1:0]  acc_type = '0;

   logic [31:0] pa_d, span_d, pa_i, span_i;
   logic        r_d, w_d, x_d, dn_d, r_i, w_i, x_i, dn_i;
   logic [1:0]  cz_d, cz_i;

   int checks = 0;
   int errors = 0;

   logic [2:0] m_reg  [8];
   logic [3:0] m_attr [8];

   always #4 clk = ~clk;

   rxl_region_xlate #(.SIDE_DATA(1'b1)) dut_i (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_idx(wr_idx),
      .wr_base(wr_base), .wr_attr(wr_attr), .va(va), .acc_type(acc_type),
      .pa(pa_d), .span(span_d), .perm_r(r_d), .perm_w(w_d), .perm_x(x_d),
      .deny(dn_d), .cause(cz_d));

   rxl_region_xlate #(.SIDE_DATA(1'b0)) dut_ins (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_idx(wr_idx),
      .wr_base(wr_base), .wr_attr(wr_attr), .va(va), .acc_type(acc_type),
      .pa(pa_i), .span(span_i), .perm_r(r_i), .perm_w(w_i), .perm_x(x_i),
      .deny(dn_i), .cause(cz_i));

   function automatic bit f_rw(input int a);
      return ((a < 6) && (a != 3)) || (a == 14);
   endfunction

   function automatic bit f_x(input int a);
      return (a >= 1) && (a <= 5);
   endfunction

   task automatic chk(input bit ok, input string req, input string what,
                      input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
      end
   endtask

   // Drive a lookup (after a falling edge) and compare every output with the model.
   task automatic probe(input int idx, input logic [28:0] off, input int typ);
      logic [31:0] exp_pa;
      bit          rw, xx;
      logic [1:0]  ecd, eci;
      va       = {idx[2:0], off};
      acc_type = typ[1:0];
      #1;
      exp_pa = {m_reg[idx], off};
      rw = f_rw(int'(m_attr[idx]));
      xx = f_x(int'(m_attr[idx]));
      if (typ == 1)      ecd = rw ? 2'd0 : 2'd2;
      else if (typ == 2) ecd = xx ? 2'd0 : 2'd3;
      else               ecd = rw ? 2'd0 : 2'd1;
      eci = xx ? 2'd0 : 2'd3;
      chk(pa_d == exp_pa && pa_i == exp_pa, "R2", "pa", pa_d, exp_pa);
      chk(span_d == 32'h2000_0000 && span_i == 32'h2000_0000, "R3", "span",
          span_d, 32'h2000_0000);
      chk(r_d == rw && w_d == rw && r_i == rw && w_i == rw, "R4", "rw",
          {30'd0, r_d, w_d}, {30'd0, rw, rw});
      chk(x_d == xx && x_i == xx, "R5", "x", {31'd0, x_d}, {31'd0, xx});
      chk(cz_d == ecd && dn_d == (ecd != 2'd0), "R6", "data cause",
          {29'd0, dn_d, cz_d}, {29'd0, ecd != 2'd0, ecd});
      chk(cz_i == eci && dn_i == (eci != 2'd0), "R7", "insn cause",
          {29'd0, dn_i, cz_i}, {29'd0, eci != 2'd0, eci});
   endtask

   task automatic wr(input int idx, input logic [31:0] base, input int attr, input bit en);
      @(negedge clk);
      wr_en   = en;
      wr_idx  = idx[2:0];
      wr_base = base;
      wr_attr = attr[3:0];
      @(posedge clk);
      @(negedge clk);
      wr_en = 1'b0;
      if (en) begin
         m_reg[idx]  = base[31:29];
         m_attr[idx] = attr[3:0];
      end
   endtask

   initial begin
      #(8 * 100000);
      errors++;
      $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      for (int i = 0; i < 8; i++) begin
         m_reg[i]  = i[2:0];
         m_attr[i] = 4'd2;
      end
      repeat (3) @(posedge clk);
      @(negedge clk);
      rst_n = 1'b1;

      // R1: identity map with full permissions out of reset
      for (int i = 0; i < 8; i++) begin
         for (int t = 0; t < 4; t++) begin
            probe(i, 29'h0ABC_1234 ^ 29'(i * 77), t);
            chk(pa_d == va && r_d && w_d && x_d && !dn_d && !dn_i, "R1",
                "reset map", pa_d, va);
         end
      end

      // Attribute sweep: every attribute on a moving region, all four types
      for (int a = 0; a < 16; a++) begin
         int k;
         logic [31:0] b;
         k = a % 8;
         b = {3'((a * 5 + 3) % 8), 29'h1555_5555 ^ 29'(a)};
         wr(k, b, a, 1'b1);
         for (int t = 0; t < 4; t++) begin
            probe(k, 29'h1FFF_FFFF - 29'(a * 4099 + t), t);
            chk(pa_d[31:29] == b[31:29] && pa_d[28:0] == va[28:0], "R9",
                "base low bits dropped", pa_d, {b[31:29], va[28:0]});
         end
         // R8: every other entry keeps its model value
         for (int j = 0; j < 8; j++) begin
            probe(j, 29'h0000_0010, 0);
            chk(pa_d[31:29] == m_reg[j], "R8", "entry after write",
                {29'd0, pa_d[31:29]}, {29'd0, m_reg[j]});
         end
      end

      // Offset extremes on one region
      probe(3, 29'h0, 1);
      probe(3, 29'h1FFF_FFFF, 2);

      // R10: strobe low leaves every entry alone
      wr(6, 32'h0000_0000, 9, 1'b0);
      for (int j = 0; j < 8; j++) begin
         for (int t = 0; t < 3; t++) probe(j, 29'h0123_4567, t);
         chk(pa_d[31:29] == m_reg[j] && x_d == f_x(int'(m_attr[j])), "R10",
             "idle write", {28'd0, x_d, pa_d[31:29]},
             {28'd0, f_x(int'(m_attr[j])), m_reg[j]});
      end

      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule